// File: doc/BRIEF.md
# Transmitter Operating Mode Sequencer

This block sequences the operating modes of a low-power radio transmitter. It watches the enable pin and the shared data pin, an oscillator-ready flag from the analog crystal oscillator, and two event pulses from the serial configuration loader. The first pulse reports that the register is partly loaded, once the band bit is in. The second reports that the register is fully loaded. It also takes the decoded configuration bits it needs: clock-only, ASK/FSK, clock-on and divide-by-4. From these it drives per-block enables for the oscillator, the PLL, the power amplifier and the clock driver. It asks the loader to accept a fresh 32-bit word, and it produces a divided reference clock that never shows a runt pulse.

A normal burst goes through two start-up modes. The first has only the oscillator and control logic on. The second adds the PLL. A fixed lock wait follows, then the transmit modes. In transmit mode one the PLL runs and the amplifier is off. In transmit mode two the amplifier is also on. In ASK operation the data pin gates the amplifier.

Pulling enable low while data is high parks the block in a reset-register mode. There the oscillator keeps running so the register can be rewritten without a new oscillator start-up. A clock-only mode keeps just the oscillator and the clock driver alive.

Top module: `txmode_seq`

## Requirements
- R1: After reset, mode_o is 0 (off) and osc_en, pll_en, pa_en, clkdrv_en, reload_req and clk_out are all low.
- R2: With enable high and data low in off mode, the next mode is start-up 1 (code 1). reload_req is high for exactly the first cycle after each entry into start-up 1 or configuration 1 (code 7).
- R3: Enable low with data low returns the block to off (code 0) on the next cycle, from any mode.
- R4: Enable low with data high, in any mode other than off, enters reset-register mode (code 6). In that mode osc_en is high and pll_en and pa_en are low. In off mode the same input pattern keeps the block off.
- R5: In reset-register mode every clock edge sampled with enable low is counted, up to HOLD_CYCLES. When enable is sampled high, the block goes to configuration 1 (code 7) if the count has reached HOLD_CYCLES, and otherwise to off (code 0).
- R6: A partly-loaded pulse with the clock-only bit low moves start-up 1 to start-up 2 (code 2), and configuration 1 to configuration 2 (code 8). pll_en is high exactly in modes 2, 3, 4 and 8.
- R7: In start-up 1 or configuration 1, the block enters clock-only mode (code 5) when the clock-only bit is high, oscillator-ready is high, and a fully-loaded pulse is present now or was seen earlier in the current load. pll_en and pa_en are low in clock-only mode.
- R8: In modes 2 and 8, the block enters transmit 1 (code 3) after LOCK_CYCLES consecutive clock edges with the register fully loaded and oscillator-ready high. A drop of oscillator-ready restarts the count.
- R9: With the FSK setting (ask bit 0), transmit 1 moves to transmit 2 (code 4) on the next cycle. With the ASK setting (ask bit 1), the move needs data high, and data low in transmit 2 returns to transmit 1. pa_en is high only in mode 4.
- R10: Loader event pulses have no effect in off, transmit 1, transmit 2, clock-only or reset-register mode.
- R11: clkdrv_en is high exactly when the mode is not off, clock-on is high and oscillator-ready is high.
- R12: clk_out has a period of DIV_FAST cycles when the divide-by-4 bit is high and DIV_SLOW cycles when it is low, with the first half of each period high. It starts one cycle after clkdrv_en rises, and it stops or changes ratio only at the end of a full period. It is low whenever the mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock from the crystal oscillator |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_pin | input | 1 | Enable pin level |
| dat_pin | input | 1 | Serial data / transmit data pin level |
| osc_rdy | input | 1 | Oscillator amplitude is sufficient |
| ev_part | input | 1 | One-cycle pulse: register partly loaded (band bit in) |
| ev_done | input | 1 | One-cycle pulse: register fully loaded |
| cfg_clkonly | input | 1 | Decoded clock-only bit |
| cfg_ask | input | 1 | Decoded modulation bit, 1 = ASK, 0 = FSK |
| cfg_clkon | input | 1 | Decoded clock-output enable bit |
| cfg_div4 | input | 1 | Decoded divider bit, 1 = divide by DIV_FAST, 0 = by DIV_SLOW |
| mode_o | output | 4 | Current operating mode code |
| osc_en | output | 1 | Oscillator and control logic powered |
| pll_en | output | 1 | Fractional-N PLL enable |
| pa_en | output | 1 | Power amplifier enable |
| clkdrv_en | output | 1 | Clock driver enable request |
| reload_req | output | 1 | One-cycle request for the loader to accept a new word |
| clk_out | output | 1 | Divided reference clock output |

## Verification
The hardest case to reach from the ports is the edge of the reset-register hold window. One extra or one missing cycle of enable low decides between reconfiguration and a full power-down. The stimulus holds enable low from a transmit mode for exactly HOLD_CYCLES+1 edges and then for exactly HOLD_CYCLES edges, and expects configuration 1 in the first case and off in the second. A second hard case is the clock output turning off in the middle of a period. Clock-on is dropped while the divided clock is high, and the per-cycle model checks that the period still runs to its end.

// File: rtl/txseq_pkg.sv
package txseq_pkg;

  typedef enum logic [3:0] {
    M_OFF     = 4'd0,
    M_START1  = 4'd1,
    M_START2  = 4'd2,
    M_TX1     = 4'd3,
    M_TX2     = 4'd4,
    M_CLKONLY = 4'd5,
    M_RSTREG  = 4'd6,
    M_CFG1    = 4'd7,
    M_CFG2    = 4'd8
  } mode_t;

  // PLL runs in the second start-up / configuration modes and in transmit
  function automatic logic pll_on(mode_t m);
    return (m == M_START2) || (m == M_CFG2) || (m == M_TX1) || (m == M_TX2);
  endfunction

  function automatic logic pa_on(mode_t m);
    return m == M_TX2;
  endfunction

  // modes in which the loader starts receiving a fresh word
  function automatic logic loads_word(mode_t m);
    return (m == M_START1) || (m == M_CFG1);
  endfunction

  // modes in which loader events are honoured
  function automatic logic takes_events(mode_t m);
    return (m == M_START1) || (m == M_START2) || (m == M_CFG1) || (m == M_CFG2);
  endfunction

  // modes that wait for PLL lock
  function automatic logic waits_lock(mode_t m);
    return (m == M_START2) || (m == M_CFG2);
  endfunction

endpackage

// File: rtl/txseq_span.sv
module txseq_span #(
  parameter int LIMIT = 130
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hit,
  output logic full
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);
  localparam logic [W-1:0] TOP  = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (cnt_q != TOP) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // hit: this edge completes LIMIT consecutive run cycles
  assign hit  = run && (cnt_q == LAST);
  // full: LIMIT run cycles have already been counted
  assign full = (cnt_q == TOP);

endmodule

// File: rtl/txseq_fsm.sv
module txseq_fsm
  import txseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  dat,
  input  logic  osc_rdy,
  input  logic  ev_part,
  input  logic  ev_done,
  input  logic  cfg_clkonly,
  input  logic  cfg_ask,
  input  logic  lock_hit,
  input  logic  hold_full,
  output mode_t mode,
  output logic  reload_q,
  output logic  lock_run,
  output logic  hold_run
);
  mode_t nxt;
  logic  prog_q;
  logic  enter_load;

  always_comb begin
    nxt = mode;
    if (!en && !dat) begin
      nxt = M_OFF;
    end else if (!en) begin
      nxt = (mode == M_OFF) ? M_OFF : M_RSTREG;
    end else begin
      case (mode)
        M_OFF: begin
          if (!dat) nxt = M_START1;
        end
        M_START1, M_CFG1: begin
          if (ev_part && !cfg_clkonly) begin
            nxt = (mode == M_START1) ? M_START2 : M_CFG2;
          end else if ((ev_done || prog_q) && cfg_clkonly && osc_rdy) begin
            nxt = M_CLKONLY;
          end
        end
        M_START2, M_CFG2: begin
          if (lock_hit) nxt = M_TX1;
        end
        M_TX1: begin
          if (!cfg_ask || dat) nxt = M_TX2;
        end
        M_TX2: begin
          if (cfg_ask && !dat) nxt = M_TX1;
        end
        M_RSTREG: begin
          nxt = hold_full ? M_CFG1 : M_OFF;
        end
        default: nxt = mode;
      endcase
    end
  end

  assign enter_load = (nxt != mode) && loads_word(nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= M_OFF;
      prog_q   <= 1'b0;
      reload_q <= 1'b0;
    end else begin
      mode     <= nxt;
      reload_q <= enter_load;
      if ((nxt == M_OFF) || enter_load) begin
        prog_q <= 1'b0;
      end else if (ev_done && takes_events(mode)) begin
        prog_q <= 1'b1;
      end
    end
  end

  assign lock_run = waits_lock(mode) && prog_q && osc_rdy;
  assign hold_run = (mode == M_RSTREG) && !en;

endmodule

// File: rtl/txseq_clkdiv.sv
module txseq_clkdiv #(
  parameter int DIV_FAST = 4,
  parameter int DIV_SLOW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr,
  input  logic drv_en,
  input  logic sel_fast,
  output logic clk_out,
  output logic at_boundary
);
  localparam int CW = $clog2(DIV_SLOW);
  localparam int PW = CW + 1;

  logic          gate_q;
  logic          sel_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] per;

  function automatic logic [PW-1:0] period_of(logic fast);
    return fast ? PW'(DIV_FAST) : PW'(DIV_SLOW);
  endfunction

  assign per         = period_of(sel_q);
  assign at_boundary = gate_q && ({1'b0, cnt_q} == (per - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      sel_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (!pwr) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!gate_q) begin
      cnt_q <= '0;
      if (drv_en) begin
        gate_q <= 1'b1;
        sel_q  <= sel_fast;
      end
    end else if (at_boundary) begin
      cnt_q  <= '0;
      gate_q <= drv_en;
      sel_q  <= sel_fast;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clk_out = gate_q && pwr && ({1'b0, cnt_q} < (per >> 1));

endmodule

// File: rtl/txmode_seq.sv
module txmode_seq
  import txseq_pkg::*;
#(
  parameter int LOCK_CYCLES = 1280,
  parameter int HOLD_CYCLES = 130,
  parameter int DIV_FAST    = 4,
  parameter int DIV_SLOW    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_pin,
  input  logic       dat_pin,
  input  logic       osc_rdy,
  input  logic       ev_part,
  input  logic       ev_done,
  input  logic       cfg_clkonly,
  input  logic       cfg_ask,
  input  logic       cfg_clkon,
  input  logic       cfg_div4,
  output logic [3:0] mode_o,
  output logic       osc_en,
  output logic       pll_en,
  output logic       pa_en,
  output logic       clkdrv_en,
  output logic       reload_req,
  output logic       clk_out
);
  mode_t mode;
  logic  lock_run, lock_hit, lock_full;
  logic  hold_run, hold_hit, hold_full;
  logic  div_boundary;

  txseq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en_pin),
    .dat        (dat_pin),
    .osc_rdy    (osc_rdy),
    .ev_part    (ev_part),
    .ev_done    (ev_done),
    .cfg_clkonly(cfg_clkonly),
    .cfg_ask    (cfg_ask),
    .lock_hit   (lock_hit),
    .hold_full  (hold_full),
    .mode       (mode),
    .reload_q   (reload_req),
    .lock_run   (lock_run),
    .hold_run   (hold_run)
  );

  txseq_span #(.LIMIT(LOCK_CYCLES)) u_lock (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (lock_run),
    .hit  (lock_hit),
    .full (lock_full)
  );

  txseq_span #(.LIMIT(HOLD_CYCLES)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (hold_run),
    .hit  (hold_hit),
    .full (hold_full)
  );

  assign mode_o    = mode;
  assign osc_en    = (mode != M_OFF);
  assign pll_en    = pll_on(mode);
  assign pa_en     = pa_on(mode);
  assign clkdrv_en = osc_en && cfg_clkon && osc_rdy;

  txseq_clkdiv #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr        (osc_en),
    .drv_en     (clkdrv_en),
    .sel_fast   (cfg_div4),
    .clk_out    (clk_out),
    .at_boundary(div_boundary)
  );

endmodule

// File: rtl/txmode_seq_chk.sv
module txmode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_pin,
  input logic       dat_pin,
  input logic [3:0] mode_o,
  input logic       osc_en,
  input logic       pll_en,
  input logic       pa_en,
  input logic       reload_req,
  input logic       clk_out,
  input logic       lock_hit,
  input logic       hold_full
);

  a_r3_idle_pins_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_pin && !dat_pin) |=> (mode_o == 4'd0));

  a_r4_rstreg_pll_pa_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 4'd6) |-> (osc_en && !pll_en && !pa_en));

  a_r9_pa_only_tx2: assert property (@(posedge clk) disable iff (!rst_n)
    pa_en |-> (mode_o == 4'd4));

  a_r8_lock_before_tx1: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == 4'd3) && (($past(mode_o) == 4'd2) || ($past(mode_o) == 4'd8)))
      |-> $past(lock_hit));

  a_r5_hold_before_cfg1: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == 4'd7) && ($past(mode_o) == 4'd6)) |-> $past(hold_full));

  a_r12_off_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 4'd0) |-> !clk_out);

  a_r12_no_runt_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clk_out) && osc_en) |=> (clk_out || !osc_en));

  a_r2_reload_single: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req |=> !reload_req);

endmodule

bind txmode_seq txmode_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_pin    (en_pin),
  .dat_pin   (dat_pin),
  .mode_o    (mode_o),
  .osc_en    (osc_en),
  .pll_en    (pll_en),
  .pa_en     (pa_en),
  .reload_req(reload_req),
  .clk_out   (clk_out),
  .lock_hit  (lock_hit),
  .hold_full (hold_full)
);

// File: tb/txmode_seq_tb.sv
`timescale 1ns/1ps
module txmode_seq_tb;
  localparam int LOCK = 1280;
  localparam int HOLD = 130;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_pin = 0, dat_pin = 0, osc_rdy = 0, ev_part = 0, ev_done = 0;
  logic cfg_clkonly = 0, cfg_ask = 0, cfg_clkon = 0, cfg_div4 = 0;
  logic [3:0] mode_o;
  logic osc_en, pll_en, pa_en, clkdrv_en, reload_req, clk_out;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  txmode_seq #(.LOCK_CYCLES(LOCK), .HOLD_CYCLES(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .dat_pin(dat_pin),
    .osc_rdy(osc_rdy), .ev_part(ev_part), .ev_done(ev_done),
    .cfg_clkonly(cfg_clkonly), .cfg_ask(cfg_ask), .cfg_clkon(cfg_clkon),
    .cfg_div4(cfg_div4), .mode_o(mode_o), .osc_en(osc_en), .pll_en(pll_en),
    .pa_en(pa_en), .clkdrv_en(clkdrv_en), .reload_req(reload_req),
    .clk_out(clk_out)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // behavioural reference model
  int st = 0, lockc = 0, holdc = 0, ccnt = 0, cper = 8;
  bit prog = 0, rel = 0, cgate = 0;

  always @(posedge clk) begin
    int ns;
    bit on, drv, load_entry;
    if (!rst_n) begin
      st = 0; lockc = 0; holdc = 0; prog = 0; rel = 0;
      cgate = 0; ccnt = 0; cper = 8;
    end else begin
      on  = (st != 0);
      drv = on && cfg_clkon && osc_rdy;
      ns  = st;
      if (!en_pin && !dat_pin) ns = 0;
      else if (!en_pin) ns = (st == 0) ? 0 : 6;
      else begin
        if (st == 0 && !dat_pin) ns = 1;
        else if (st == 1 || st == 7) begin
          if (ev_part && !cfg_clkonly) ns = st + 1 + ((st == 7) ? 0 : 0);
          else if ((ev_done || prog) && cfg_clkonly && osc_rdy) ns = 5;
          if (ns == 8 && st == 7) ns = 8;
          if (st == 7 && ns == 8) ns = 8;
        end
        else if (st == 2 || st == 8) begin
          if (prog && osc_rdy && (lockc + 1 == LOCK)) ns = 3;
        end
        else if (st == 3) begin if (!cfg_ask || dat_pin) ns = 4; end
        else if (st == 4) begin if (cfg_ask && !dat_pin) ns = 3; end
        else if (st == 6) ns = (holdc >= HOLD) ? 7 : 0;
      end
      // counters
      if ((st == 2 || st == 8) && prog && osc_rdy) lockc++; else lockc = 0;
      if (st == 6 && !en_pin) begin if (holdc < HOLD) holdc++; end else holdc = 0;
      load_entry = (ns != st) && (ns == 1 || ns == 7);
      if (ns == 0 || load_entry) prog = 0;
      else if (ev_done && (st == 1 || st == 2 || st == 7 || st == 8)) prog = 1;
      rel = load_entry;
      // divided clock
      if (!on) begin cgate = 0; ccnt = 0; end
      else if (!cgate) begin
        ccnt = 0;
        if (drv) begin cgate = 1; cper = cfg_div4 ? 4 : 8; end
      end else if (ccnt == cper - 1) begin
        ccnt = 0; cgate = drv; cper = cfg_div4 ? 4 : 8;
      end else ccnt++;
      st = ns;
    end
  end

  // per-cycle comparison, away from the edge
  always begin
    @(posedge clk);
    #1;
    if (rst_n && !finished) begin
      chk("R6 mode", mode_o, st);
      chk("R4 osc_en", osc_en, st != 0);
      chk("R6 pll_en", pll_en, (st == 2 || st == 3 || st == 4 || st == 8));
      chk("R9 pa_en", pa_en, st == 4);
      chk("R11 clkdrv_en", clkdrv_en, (st != 0) && cfg_clkon && osc_rdy);
      chk("R12 clk_out", clk_out, cgate && (st != 0) && (ccnt < cper / 2));
      chk("R2 reload_req", reload_req, rel);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_part();
    ev_part = 1; step(1); ev_part = 0;
  endtask

  task automatic pulse_done();
    ev_done = 1; step(1); ev_done = 0;
  endtask

  task automatic count_rises(int n, output int rises);
    logic prev;
    rises = 0;
    prev = clk_out;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (clk_out && !prev) rises++;
      prev = clk_out;
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int r;
    step(3);
    // R1 reset state
    chk("R1 mode", mode_o, 0);
    chk("R1 enables", {osc_en, pll_en, pa_en, clkdrv_en, reload_req, clk_out}, 0);
    rst_n = 1;
    step(2);
    // R4: enable low data high in off keeps off
    dat_pin = 1; step(3);
    chk("R4 off stays off", mode_o, 0);
    dat_pin = 0;
    // R2 start-up
    en_pin = 1; step(1);
    chk("R2 start1", mode_o, 1);
    chk("R2 reload pulse", reload_req, 1);
    step(1);
    chk("R2 reload single", reload_req, 0);
    // R6 partial load
    pulse_part();
    chk("R6 start2", mode_o, 2);
    chk("R6 pll on", pll_en, 1);
    pulse_done();
    step(20);
    chk("R8 no lock without osc ready", mode_o, 2);
    cfg_clkon = 1; osc_rdy = 1;
    step(LOCK - 2);
    chk("R8 still waiting", mode_o, 2);
    step(4);
    chk("R9 fsk reaches tx2", mode_o, 4);
    chk("R9 pa on", pa_en, 1);
    count_rises(32, r);
    chk("R12 slow ratio rises", r, 4);
    // R10 events ignored in transmit
    cfg_clkonly = 1; pulse_part(); pulse_done(); step(2);
    chk("R10 tx2 kept", mode_o, 4);
    cfg_clkonly = 0;
    // R5 long hold: HOLD+1 low edges -> config1
    en_pin = 0; dat_pin = 1; step(HOLD + 1);
    chk("R4 rstreg", mode_o, 6);
    chk("R4 pll off", pll_en, 0);
    pulse_done();
    chk("R10 rstreg kept", mode_o, 6);
    en_pin = 1; step(1);
    chk("R5 long hold to cfg1", mode_o, (HOLD + 1 - 1 + 1 - 1 >= HOLD) ? 7 : 0);
    chk("R2 reload on cfg1", reload_req, 1);
    dat_pin = 0; cfg_ask = 1; cfg_div4 = 1;
    pulse_part();
    chk("R6 cfg2", mode_o, 8);
    pulse_done();
    step(LOCK + 4);
    chk("R8 cfg2 lock tx1", mode_o, 3);
    chk("R9 ask waits data", pa_en, 0);
    count_rises(32, r);
    chk("R12 fast ratio rises", r, 8);
    dat_pin = 1; step(1);
    chk("R9 ask data high tx2", mode_o, 4);
    dat_pin = 0; step(1);
    chk("R9 ask data low tx1", mode_o, 3);
    // R5 short hold: HOLD low edges -> off
    dat_pin = 1; en_pin = 0; step(HOLD);
    en_pin = 1; step(1);
    chk("R5 short hold to off", mode_o, 0);
    dat_pin = 0; step(1);
    chk("R2 restart", mode_o, 1);
    // R7 clock-only
    osc_rdy = 0; cfg_clkonly = 1;
    pulse_done(); step(3);
    chk("R7 waits osc ready", mode_o, 1);
    osc_rdy = 1; step(1);
    chk("R7 clock only", mode_o, 5);
    chk("R7 pll off", pll_en, 0);
    pulse_part(); step(2);
    chk("R10 clock only kept", mode_o, 5);
    // R12 mid-period turn-off, checked by the per-cycle model
    while (!clk_out) step(1);
    cfg_clkon = 0; step(1);
    chk("R11 driver off", clkdrv_en, 0);
    chk("R12 high half continues", clk_out, 1);
    step(10);
    chk("R12 stopped", clk_out, 0);
    // R3 return to off
    cfg_clkon = 1; step(6);
    en_pin = 0; dat_pin = 0; step(1);
    chk("R3 off", mode_o, 0);
    chk("R12 off low", clk_out, 0);
    step(4);
    summary();
  end
endmodule